// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the register front end of a simple LCD controller. A 32-bit register bus reaches six word-wide registers inside a 256-byte window. The registers hold the panel control word, three timing words, a read-only status word and a subpanel word. The block passes the panel enable and a one-cycle enable-change pulse to the frame fetch sequencer. It receives three event pulses from that sequencer: frame done, palette loaded and sync error.

The three event pulses set sticky status flags. The block drives one level interrupt from those flags and a two-bit enable mask; a sync error raises the interrupt whatever the mask holds. Some fields come back from a read with fixed constant bits ORed in. Width and height are kept as the written value, which is the dimension minus one. The upper timing bits are stored and read back but have no effect here. Read data is registered, and an access to an unmapped offset raises a one-cycle error strobe.

Top module: `lcdc_regs`

## Requirements
- R1: The register index is address bits 7:2, and address bits 1:0 are ignored. Index 0 is control, 1 is timing0, 2 is timing1, 3 is timing2, 4 is status and 5 is subpanel.
- R2: A control write stores the following fields: load mode from bits 21:20, TFT from bit 7, interrupt mask from bits 4:3, mono from bit 1 and enable from bit 0. It also keeps the bits under 0x01CFF300. A control read returns these fields at the same positions, with TFT also at bit 23. The read value is ORed with the kept bits and with 0xFE000C34.
- R3: A timing0 or timing1 write keeps all 32 bits, where bits 9:0 are the dimension minus one. A timing1 read returns the stored value unchanged. A timing0 read returns the stored value ORed with 0x0000000F.
- R4: A timing2 read returns the stored word ORed with 0xFC000000. A subpanel write stores the data ANDed with 0xA1FFFFFF.
- R5: A status read returns palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with all other bits zero. A status write changes nothing.
- R6: The interrupt is high when any of these holds: frame-done is set and mask bit 0 (control bit 3) is set; palette-done is set and mask bit 1 (control bit 4) is set; sync-error is set, whatever the mask. Otherwise the interrupt is low.
- R7: The interrupt is a register. It reflects a flag or mask change one clock after the edge at which that change takes effect.
- R8: `en_change` goes high for exactly one cycle after a control write that changes the enable bit. A control write with the same enable value gives no pulse.
- R9: A control write that turns enable on clears frame-done and palette-done. A control write that turns enable off clears sync-error. An event pulse in the same cycle as the clear sets its flag.
- R10: An access with a register index of 6 or more reads as zero and changes no register. It raises `bad_access` for one cycle, one clock after the access.
- R11: After reset, every field, flag, `irq`, `en_change` and `bad_access` is zero. Reads then return 0xFE000C34 for control, 0x0000000F for timing0, 0 for timing1, 0xFC000000 for timing2, 0 for status and 0 for subpanel.
- R12: `rdata` holds the value read at the clock edge where `rd_en` is high. It keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte offset in the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle strobe for an unmapped access |
| ev_frame | input | 1 | Frame-done event pulse |
| ev_palette | input | 1 | Palette-loaded event pulse |
| ev_sync | input | 1 | Sync-error event pulse |
| irq | output | 1 | Registered level interrupt |
| en_change | output | 1 | One-cycle pulse when the enable bit changes |
| panel_en | output | 1 | Current enable bit |

## Verification
The bench builds the block with its default parameters: ADDR_W of 8 and DIM_W of 10. With these values the six mapped indices and the unmapped indices 6 to 63 can all be reached from the bench. The 10-bit dimension field sits where the constant read-back patterns and the width/height layout expect it. The bench checks each mask combination of the interrupt, counted edge by edge. It also checks the enable clears that run together with event pulses in the same cycle.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_REGS  = 6;
    localparam int NUM_FLAGS = 3;
    localparam int FL_FRAME  = 0;
    localparam int FL_PAL    = 1;
    localparam int FL_SYNC   = 2;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_TIM0 = 3'd1,
        RG_TIM1 = 3'd2,
        RG_TIM2 = 3'd3,
        RG_STAT = 3'd4,
        RG_SUBP = 3'd5
    } reg_idx_e;

    localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [DATA_W-1:0] CTRL_RD_ONES   = 32'hFE00_0C34;
    localparam logic [DATA_W-1:0] TIM0_RD_ONES   = 32'h0000_000F;
    localparam logic [DATA_W-1:0] TIM2_RD_ONES   = 32'hFC00_0000;
    localparam logic [DATA_W-1:0] SUBP_WR_MASK   = 32'hA1FF_FFFF;
endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_idx_e          idx,
    output logic              hit
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              lowbits_unused;

    assign word           = addr[ADDR_W-1:2];
    assign lowbits_unused = ^addr[1:0];

    always_comb begin
        hit = (word < WORD_W'(NUM_REGS));
        idx = hit ? reg_idx_e'(word[2:0]) : RG_CTRL;
    end
endmodule

// File: rtl/lcdc_flag_bank.sv
module lcdc_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d;
    logic [N-1:0] flags_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb begin
            flags_d[i] = flags_q[i];
            if (clr[i]) flags_d[i] = 1'b0;
            if (set[i]) flags_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/lcdc_irq_gen.sv
module lcdc_irq_gen
    import lcdc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [1:0]           mask,
    output logic                 irq
);
    logic irq_d;
    logic irq_q;

    always_comb begin
        irq_d = 1'b0;
        if (flags[FL_FRAME] && mask[0])    irq_d = 1'b1;
        else if (flags[FL_PAL] && mask[1]) irq_d = 1'b1;
        else if (flags[FL_SYNC])           irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              bad_access,
    input  logic              ev_frame,
    input  logic              ev_palette,
    input  logic              ev_sync,
    output logic              irq,
    output logic              en_change,
    output logic              panel_en
);
    localparam int HI_W = DATA_W - DIM_W;

    typedef struct packed {
        logic [1:0]        plm;
        logic              tft;
        logic [1:0]        ie;
        logic              mono;
        logic              en;
        logic [DATA_W-1:0] keep;
        logic [HI_W-1:0]   t0_hi;
        logic [DIM_W-1:0]  w_m1;
        logic [HI_W-1:0]   t1_hi;
        logic [DIM_W-1:0]  h_m1;
        logic [DATA_W-1:0] t2;
        logic [DATA_W-1:0] sub;
        logic [DATA_W-1:0] rdata;
        logic              bad;
        logic              en_chg;
    } state_t;

    state_t               s_d, s_q;
    reg_idx_e             idx;
    logic                 hit;
    logic                 ctrl_wr;
    logic                 en_rise, en_fall;
    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] fl_set, fl_clr;
    logic [1:0]           ie_q;
    logic [DATA_W-1:0]    rd_mux;

    lcdc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .idx  (idx),
        .hit  (hit)
    );

    assign ctrl_wr = wr_en && hit && (idx == RG_CTRL);
    assign en_rise = ctrl_wr && wdata[0] && !s_q.en;
    assign en_fall = ctrl_wr && !wdata[0] && s_q.en;

    always_comb begin
        fl_set           = '0;
        fl_set[FL_FRAME] = ev_frame;
        fl_set[FL_PAL]   = ev_palette;
        fl_set[FL_SYNC]  = ev_sync;
        fl_clr           = '0;
        fl_clr[FL_FRAME] = en_rise;
        fl_clr[FL_PAL]   = en_rise;
        fl_clr[FL_SYNC]  = en_fall;
    end

    lcdc_flag_bank #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fl_set),
        .clr   (fl_clr),
        .flags (flags_q)
    );

    assign ie_q = s_q.ie;

    lcdc_irq_gen u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flags_q),
        .mask  (ie_q),
        .irq   (irq)
    );

    always_comb begin
        rd_mux = '0;
        case (idx)
            RG_CTRL: rd_mux = ({8'd0, s_q.tft, 1'b0, s_q.plm, 12'd0,
                                s_q.tft, 2'd0, s_q.ie, 1'b0, s_q.mono, s_q.en}
                               | s_q.keep | CTRL_RD_ONES);
            RG_TIM0: rd_mux = {s_q.t0_hi, s_q.w_m1} | TIM0_RD_ONES;
            RG_TIM1: rd_mux = {s_q.t1_hi, s_q.h_m1};
            RG_TIM2: rd_mux = s_q.t2 | TIM2_RD_ONES;
            RG_STAT: begin
                rd_mux[6] = flags_q[FL_PAL];
                rd_mux[2] = flags_q[FL_SYNC];
                rd_mux[0] = flags_q[FL_FRAME];
            end
            RG_SUBP: rd_mux = s_q.sub;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        s_d        = s_q;
        s_d.en_chg = 1'b0;
        s_d.bad    = 1'b0;
        if (wr_en && hit) begin
            case (idx)
                RG_CTRL: begin
                    s_d.plm  = wdata[21:20];
                    s_d.tft  = wdata[7];
                    s_d.ie   = wdata[4:3];
                    s_d.mono = wdata[1];
                    s_d.keep = wdata & CTRL_KEEP_MASK;
                    if (wdata[0] != s_q.en) begin
                        s_d.en     = wdata[0];
                        s_d.en_chg = 1'b1;
                    end
                end
                RG_TIM0: {s_d.t0_hi, s_d.w_m1} = wdata;
                RG_TIM1: {s_d.t1_hi, s_d.h_m1} = wdata;
                RG_TIM2: s_d.t2  = wdata;
                RG_SUBP: s_d.sub = wdata & SUBP_WR_MASK;
                default: ;
            endcase
        end
        if ((wr_en || rd_en) && !hit) s_d.bad = 1'b1;
        if (rd_en) s_d.rdata = hit ? rd_mux : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata      = s_q.rdata;
    assign bad_access = s_q.bad;
    assign en_change  = s_q.en_chg;
    assign panel_en   = s_q.en;
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input logic              en_change,
    input logic              bad_access,
    input logic              enable,
    input logic [2:0]        flags,
    input logic [1:0]        mask
);
    p_irq_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags[2] |=> irq);

    p_irq_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && mask[0]) |=> irq);

    p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 3'b000) |=> !irq);

    p_chg_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_change |-> (enable != $past(enable)));

    p_chg_needs_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !en_change);

    p_bad_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> ($past(wr_en || rd_en) && ($past(addr[ADDR_W-1:2]) >= 6)));
endmodule

bind lcdc_regs lcdc_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .irq        (irq),
    .en_change  (en_change),
    .bad_access (bad_access),
    .enable     (panel_en),
    .flags      (flags_q),
    .mask       (ie_q)
);

// File: tb/sim_lcdc_regs.sv
module sim_lcdc_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        bad_access, irq, en_change, panel_en;
    logic        ev_frame = 1'b0, ev_palette = 1'b0, ev_sync = 1'b0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    lcdc_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .bad_access(bad_access),
        .ev_frame(ev_frame), .ev_palette(ev_palette), .ev_sync(ev_sync),
        .irq(irq), .en_change(en_change), .panel_en(panel_en)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] x;
    } vec_t;

    // write d to a, then read a back expecting x
    localparam vec_t VEC [10] = '{
        '{8'd2,  8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFBF},  // R2 all fields set
        '{8'd2,  8'h00, 32'h0000_0000, 32'hFE00_0C34},  // R2 cleared
        '{8'd3,  8'h04, 32'h1234_5678, 32'h1234_567F},  // R3 timing0
        '{8'd3,  8'h08, 32'hABCD_E3FF, 32'hABCD_E3FF},  // R3 timing1
        '{8'd4,  8'h0C, 32'h0000_0001, 32'hFC00_0001},  // R4 timing2
        '{8'd4,  8'h14, 32'hFFFF_FFFF, 32'hA1FF_FFFF},  // R4 subpanel
        '{8'd5,  8'h10, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 status write ignored
        '{8'd2,  8'h00, 32'h0010_0082, 32'hFE90_0CB6},  // R2 mode and TFT
        '{8'd10, 8'h18, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 unmapped
        '{8'd2,  8'h00, 32'h0000_0000, 32'hFE00_0C34}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] ev);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        {ev_sync, ev_palette, ev_frame} = ev;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        {ev_sync, ev_palette, ev_frame} = 3'b000;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(negedge clk);
        {ev_sync, ev_palette, ev_frame} = ev;
        @(posedge clk);
        @(negedge clk);
        {ev_sync, ev_palette, ev_frame} = 3'b000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk("R11 irq", {31'd0, irq}, 32'd0);
        chk("R11 en_change", {31'd0, en_change}, 32'd0);
        chk("R11 panel_en", {31'd0, panel_en}, 32'd0);
        rd(8'h00, v); chk("R11 ctrl", v, 32'hFE00_0C34);
        rd(8'h04, v); chk("R11 timing0", v, 32'h0000_000F);
        rd(8'h08, v); chk("R11 timing1", v, 32'h0);
        rd(8'h0C, v); chk("R11 timing2", v, 32'hFC00_0000);
        rd(8'h10, v); chk("R11 status", v, 32'h0);
        rd(8'h14, v); chk("R11 subpanel", v, 32'h0);

        for (int i = 0; i < 10; i++) begin
            wr(VEC[i].a, VEC[i].d, 3'b000);
            rd(VEC[i].a, v);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].x);
        end

        // R1 low address bits ignored
        rd(8'h07, v); chk("R1 addr 0x07 -> timing0", v, 32'h1234_567F);
        rd(8'h15, v); chk("R1 addr 0x15 -> subpanel", v, 32'hA1FF_FFFF);

        // R12 rdata holds between reads
        repeat (3) @(negedge clk);
        chk("R12 rdata held", rdata, 32'hA1FF_FFFF);

        // R10 error strobe
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h40; wdata = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        chk("R10 strobe on write", {31'd0, bad_access}, 32'd1);
        @(negedge clk);
        chk("R10 strobe one cycle", {31'd0, bad_access}, 32'd0);
        rd(8'hFC, v);
        chk("R10 read zero", v, 32'h0);
        chk("R10 strobe on read", {31'd0, bad_access}, 32'd1);
        rd(8'h00, v);
        chk("R10 no strobe mapped", {31'd0, bad_access}, 32'd0);
        chk("R10 ctrl untouched", v, 32'hFE00_0C34);

        // R8 enable change pulse
        wr(8'h00, 32'h1, 3'b000);
        chk("R8 pulse on rise", {31'd0, en_change}, 32'd1);
        chk("R8 panel_en", {31'd0, panel_en}, 32'd1);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'd0, en_change}, 32'd0);
        wr(8'h00, 32'h1, 3'b000);
        chk("R8 no pulse same value", {31'd0, en_change}, 32'd0);
        wr(8'h00, 32'h0, 3'b000);
        chk("R8 pulse on fall", {31'd0, en_change}, 32'd1);

        // R6 / R7 interrupt
        pulse(3'b001);
        chk("R7 irq not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R6 frame masked", {31'd0, irq}, 32'd0);
        rd(8'h10, v); chk("R5 frame flag", v, 32'h01);
        wr(8'h00, 32'h08, 3'b000);
        chk("R7 mask lag", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R6 frame enabled", {31'd0, irq}, 32'd1);
        wr(8'h00, 32'h10, 3'b000);
        @(negedge clk);
        chk("R6 frame masked by ie1 only", {31'd0, irq}, 32'd0);
        pulse(3'b010);
        @(negedge clk);
        chk("R6 palette enabled", {31'd0, irq}, 32'd1);
        rd(8'h10, v); chk("R5 palette flag", v, 32'h41);
        wr(8'h00, 32'h0, 3'b000);
        @(negedge clk);
        chk("R6 all masked", {31'd0, irq}, 32'd0);
        pulse(3'b100);
        chk("R7 sync lag", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R6 sync unmaskable", {31'd0, irq}, 32'd1);
        rd(8'h10, v); chk("R5 all flags", v, 32'h45);

        // R9 enable clears
        wr(8'h00, 32'h1, 3'b000);
        rd(8'h10, v); chk("R9 rise clears frame/palette", v, 32'h04);
        wr(8'h00, 32'h0, 3'b000);
        rd(8'h10, v); chk("R9 fall clears sync", v, 32'h00);
        chk("R6 irq low after clear", {31'd0, irq}, 32'd0);
        wr(8'h00, 32'h1, 3'b001);
        rd(8'h10, v); chk("R9 event wins over rise clear", v, 32'h01);
        wr(8'h00, 32'h0, 3'b100);
        rd(8'h10, v); chk("R9 event wins over fall clear", v, 32'h05);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule